// File: doc/BRIEF.md
# Extended Register Lock and Protection Unit

This block sits in the host register path of a display controller. It decides, for each indexed register access, whether the access may proceed and which bits of a written register may change. Host accesses name a register space, an index, the write data and a read/write flag. The block answers in the same cycle with a write enable, an eight-bit write mask and a read enable. One cycle later it returns the read data. A read that is refused returns all-ones.

Two groups of extended registers are each opened by a three-bit key that must hold the value 5. The second group also needs a two-bit read combination before it can be read. Lock bits held in those groups freeze single fields of standard sequencer, graphics, CRTC and miscellaneous registers. The rest of each register stays writable. A compatibility bit hides registers that an older adapter generation could not read back.

The protected registers are modelled as a small register file, so that every effect can be observed at the ports. The lock and key registers live in the block itself.

Top module: `xreg_guard`

## Requirements
- R1: After reset every register reads 0x00, writes to graphics indices 0x09–0x0E are refused, and reads of CRTC indices 0x2A–0x30 are refused. Spaces are encoded 0 sequencer, 1 graphics, 2 CRTC, 3 miscellaneous.
- R2: A write to graphics indices 0x09–0x0E is accepted (wr_en 1, mask 0xFF) only while bits 2:0 of graphics index 0x0F equal 5. Other bits of that key have no effect. A refused write gives wr_en 0 and mask 0x00, and leaves the register unchanged.
- R3: While bit 4 of graphics index 0x0F is set, reads of graphics indices 0x09–0x0E are refused.
- R4: A write to CRTC indices 0x2A–0x30 is accepted only while bits 2:0 of CRTC index 0x29 equal 5. Otherwise the register is unchanged.
- R5: CRTC indices 0x2A–0x30 are readable only when bit 3 of CRTC index 0x29 is 0 and bit 7 is 1.
- R6: The key registers (graphics 0x0F, CRTC 0x29) are always writable with mask 0xFF and always readable.
- R7: While bit 0 of CRTC index 0x2A is set, writes to sequencer index 1 have mask bit 0 cleared, and that bit keeps its value.
- R8: While bit 1 of CRTC index 0x2A is set, the write mask clears sequencer index 1 bits 5:2, sequencer index 3 bits 5:0 and graphics index 5 bits 6:5. The other bits of those registers are still written.
- R9: Bit 5 of graphics index 0x0D refuses writes to CRTC indices 0x00–0x05. Bit 0 refuses writes to CRTC indices 0x06, 0x07, 0x10, 0x11, 0x12, 0x15 and 0x16.
- R10: Bit 6 of graphics index 0x0D clears mask bit 6, and bit 7 clears mask bit 7, for writes to miscellaneous index 0.
- R11: While bit 1 of graphics index 0x0E is set, reads are refused for CRTC indices 0x00–0x17, miscellaneous index 0 and graphics indices 0x09–0x0E. Writes to these registers are not affected.
- R12: A read request gives rsp_valid one cycle later, with the register value if rd_en was high and 0xFF otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_space | input | 2 | Register space (0 seq, 1 gfx, 2 CRTC, 3 misc) |
| req_index | input | 6 | Register index within the space |
| req_wdata | input | 8 | Write data |
| wr_en | output | 1 | Write accepted with at least one open bit (same cycle) |
| wr_mask | output | 8 | Bits that the write may change (same cycle) |
| rd_en | output | 1 | Read permitted (same cycle) |
| rsp_valid | output | 1 | Read response valid (one cycle after request) |
| rsp_rdata | output | 8 | Read data, 0xFF when refused |

## Verification
The three qualifiers wr_en, wr_mask and rd_en are combinational on the request and the current lock state. The bench drives each request on a falling edge and samples the qualifiers one nanosecond later, before the rising edge that commits the write. Read data and rsp_valid are registered, so they are due on the first rising edge after the request and are sampled one nanosecond past it. Writes to key and lock registers take effect at that same edge. Every check that depends on a new lock state is therefore issued in a later cycle, and locked fields are confirmed by reading the register back.

// File: rtl/xreg_guard_pkg.sv
// Shared constants, types and helpers for the extended register guard.
// Assumes an 8-bit data path and a {space,index} address of SW+IW bits.
package xreg_guard_pkg;
    localparam int DW = 8;
    localparam int IW = 6;
    localparam int SW = 2;
    localparam int AW = SW + IW;
    localparam int NLOCK = 5;

    localparam logic [SW-1:0] SP_SEQ = 2'd0;
    localparam logic [SW-1:0] SP_GFX = 2'd1;
    localparam logic [SW-1:0] SP_CRT = 2'd2;
    localparam logic [SW-1:0] SP_MSC = 2'd3;

    localparam logic [2:0] KEY_OPEN = 3'd5;

    // lock register slots and their addresses
    localparam int SL_KEY_A = 0;
    localparam int SL_TIM   = 1;
    localparam int SL_VID   = 2;
    localparam int SL_KEY_B = 3;
    localparam int SL_SW    = 4;
    localparam logic [AW-1:0] LOCK_ADR [NLOCK] = '{
        {SP_GFX, 6'h0F}, {SP_GFX, 6'h0D}, {SP_GFX, 6'h0E},
        {SP_CRT, 6'h29}, {SP_CRT, 6'h2A}};

    typedef struct packed {
        logic [2:0] a_code;
        logic       a_rprot;
        logic [2:0] b_code;
        logic       b_rdis;
        logic       b_ren;
        logic       h_lk;
        logic       v_lk;
        logic       hp_lk;
        logic       vp_lk;
        logic       dot_lk;
        logic       scr_lk;
        logic       compat;
    } lock_fields_t;

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old_v,
                                            logic [DW-1:0] new_v,
                                            logic [DW-1:0] msk);
        return (old_v & ~msk) | (new_v & msk);
    endfunction

    function automatic logic in_grp_a(logic [AW-1:0] a);
        return a >= {SP_GFX, 6'h09} && a <= {SP_GFX, 6'h0E};
    endfunction

    function automatic logic in_grp_b(logic [AW-1:0] a);
        return a >= {SP_CRT, 6'h2A} && a <= {SP_CRT, 6'h30};
    endfunction

    function automatic logic in_vert(logic [AW-1:0] a);
        return a == {SP_CRT, 6'h06} || a == {SP_CRT, 6'h07} ||
               a == {SP_CRT, 6'h10} || a == {SP_CRT, 6'h11} ||
               a == {SP_CRT, 6'h12} || a == {SP_CRT, 6'h15} ||
               a == {SP_CRT, 6'h16};
    endfunction
endpackage

// File: rtl/xreg_guard_locks.sv
// Holds the key and lock registers and decodes their fields.
// Assumes the caller has already qualified wr_en and wmask.
module xreg_guard_locks
    import xreg_guard_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] wmask,
    output lock_fields_t  lk,
    output logic          hit,
    output logic [DW-1:0] hit_val
);
    logic [NLOCK-1:0][DW-1:0] lock_q;

    for (genvar g = 0; g < NLOCK; g++) begin : g_slot
        // one lock register, masked update on an address match
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[g] <= '0;
            else if (wr_en && addr == LOCK_ADR[g])
                lock_q[g] <= merge(lock_q[g], wdata, wmask);
        end
    end

    // readback mux over the lock registers
    always_comb begin
        hit     = 1'b0;
        hit_val = '0;
        for (int i = 0; i < NLOCK; i++) begin
            if (addr == LOCK_ADR[i]) begin
                hit     = 1'b1;
                hit_val = lock_q[i];
            end
        end
    end

    // field decode for the policy
    always_comb begin
        lk.a_code  = lock_q[SL_KEY_A][2:0];
        lk.a_rprot = lock_q[SL_KEY_A][4];
        lk.b_code  = lock_q[SL_KEY_B][2:0];
        lk.b_rdis  = lock_q[SL_KEY_B][3];
        lk.b_ren   = lock_q[SL_KEY_B][7];
        lk.v_lk    = lock_q[SL_TIM][0];
        lk.h_lk    = lock_q[SL_TIM][5];
        lk.hp_lk   = lock_q[SL_TIM][6];
        lk.vp_lk   = lock_q[SL_TIM][7];
        lk.compat  = lock_q[SL_VID][1];
        lk.dot_lk  = lock_q[SL_SW][0];
        lk.scr_lk  = lock_q[SL_SW][1];
    end
endmodule

// File: rtl/xreg_guard_policy.sv
// Combinational access policy: per-bit write mask and read permission.
// Assumes lock fields reflect state before the current access commits.
module xreg_guard_policy
    import xreg_guard_pkg::*;
(
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] addr,
    input  lock_fields_t  lk,
    output logic          wr_en,
    output logic [DW-1:0] wr_mask,
    output logic          rd_en
);
    logic a_open, b_open, readable;

    // key comparisons
    always_comb begin
        a_open = lk.a_code == KEY_OPEN;
        b_open = lk.b_code == KEY_OPEN;
    end

    // per-bit write mask from field locks and group keys
    always_comb begin
        wr_mask = '1;
        if (addr == {SP_SEQ, 6'h01}) begin
            if (lk.dot_lk) wr_mask[0]   = 1'b0;
            if (lk.scr_lk) wr_mask[5:2] = '0;
        end
        if (addr == {SP_SEQ, 6'h03} && lk.scr_lk) wr_mask[5:0] = '0;
        if (addr == {SP_GFX, 6'h05} && lk.scr_lk) wr_mask[6:5] = '0;
        if (addr <= {SP_CRT, 6'h05} && addr >= {SP_CRT, 6'h00} && lk.h_lk)
            wr_mask = '0;
        if (in_vert(addr) && lk.v_lk) wr_mask = '0;
        if (addr == {SP_MSC, 6'h00}) begin
            if (lk.hp_lk) wr_mask[6] = 1'b0;
            if (lk.vp_lk) wr_mask[7] = 1'b0;
        end
        if (in_grp_a(addr) && !a_open) wr_mask = '0;
        if (in_grp_b(addr) && !b_open) wr_mask = '0;
    end

    // read permission
    always_comb begin
        readable = 1'b1;
        if (in_grp_a(addr) && (lk.a_rprot || lk.compat)) readable = 1'b0;
        if (in_grp_b(addr) && !(lk.b_ren && !lk.b_rdis)) readable = 1'b0;
        if (addr >= {SP_CRT, 6'h00} && addr <= {SP_CRT, 6'h17} && lk.compat)
            readable = 1'b0;
        if (addr == {SP_MSC, 6'h00} && lk.compat) readable = 1'b0;
    end

    // final qualifiers
    always_comb begin
        wr_en = req_valid && req_write && (wr_mask != '0);
        rd_en = req_valid && !req_write && readable;
    end
endmodule

// File: rtl/xreg_guard_store.sv
// Model register file for the protected registers, written under mask.
// Assumes one access per cycle; read is asynchronous on the address.
module xreg_guard_store
    import xreg_guard_pkg::*;
#(
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] wmask,
    output logic [DW-1:0] rd_val
);
    logic [DW-1:0] mem [DEPTH];

    // masked storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[addr] <= merge(mem[addr], wdata, wmask);
        end
    end

    // asynchronous read port
    always_comb rd_val = mem[addr];
endmodule

// File: rtl/xreg_guard.sv
// Top: gates indexed host accesses to extended and standard registers.
// Qualifiers are same-cycle; read data is registered one cycle later.
module xreg_guard
    import xreg_guard_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [SW-1:0] req_space,
    input  logic [IW-1:0] req_index,
    input  logic [DW-1:0] req_wdata,
    output logic          wr_en,
    output logic [DW-1:0] wr_mask,
    output logic          rd_en,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    logic [AW-1:0] addr;
    lock_fields_t  lk;
    logic          lock_hit;
    logic [DW-1:0] lock_val, store_val, rd_val;

    // flat register address
    always_comb addr = {req_space, req_index};

    xreg_guard_locks u_locks (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(req_wdata), .wmask(wr_mask), .lk(lk),
        .hit(lock_hit), .hit_val(lock_val));

    xreg_guard_policy u_policy (
        .req_valid(req_valid), .req_write(req_write), .addr(addr), .lk(lk),
        .wr_en(wr_en), .wr_mask(wr_mask), .rd_en(rd_en));

    xreg_guard_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(req_wdata), .wmask(wr_mask), .rd_val(store_val));

    // source select for read data
    always_comb rd_val = lock_hit ? lock_val : store_val;

    // read response register, all-ones when refused
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= rd_en ? rd_val : '1;
        end
    end
endmodule

// File: rtl/xreg_guard_chk.sv
// Checker for xreg_guard, bound to every instance of the top module.
module xreg_guard_chk
    import xreg_guard_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [SW-1:0] req_space,
    input logic [IW-1:0] req_index,
    input logic          wr_en,
    input logic [DW-1:0] wr_mask,
    input logic          rd_en,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_rdata,
    input lock_fields_t  lk
);
    logic [AW-1:0] a;
    always_comb a = {req_space, req_index};

    // R12
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rsp_valid);
    // R12
    refused_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && !rd_en |=> rsp_rdata == 8'hFF);
    // R2
    grp_a_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && in_grp_a(a) |-> lk.a_code == 3'd5);
    // R3
    grp_a_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && in_grp_a(a) && lk.a_rprot |-> !rd_en);
    // R4
    grp_b_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && in_grp_b(a) |-> lk.b_code == 3'd5);
    // R5
    grp_b_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && in_grp_b(a) |-> lk.b_ren && !lk.b_rdis);
    // R6
    key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (a == {SP_GFX, 6'h0F} || a == {SP_CRT, 6'h29})
        |-> (req_write ? (wr_en && wr_mask == 8'hFF) : rd_en));
    // R7
    dot_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && lk.dot_lk && a == {SP_SEQ, 6'h01}
        |-> !wr_mask[0]);
    // R9
    hlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk.h_lk && req_space == SP_CRT && req_index <= 6'h05 |-> !wr_en);
endmodule

bind xreg_guard xreg_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_space(req_space), .req_index(req_index), .wr_en(wr_en),
    .wr_mask(wr_mask), .rd_en(rd_en), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .lk(lk));

// File: tb/xreg_guard_bench.sv
// Directed bench: one task per scenario, expected values from requirements.
module xreg_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [1:0] req_space = '0;
    logic [5:0] req_index = '0;
    logic [7:0] req_wdata = '0;
    logic       wr_en, rd_en, rsp_valid;
    logic [7:0] wr_mask, rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [1:0] SEQ = 2'd0, GFX = 2'd1, CRT = 2'd2, MSC = 2'd3;

    xreg_guard u_xreg_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_index(req_index), .req_wdata(req_wdata),
        .wr_en(wr_en), .wr_mask(wr_mask), .rd_en(rd_en),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

    always #2 clk = ~clk;

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    // write: qualifiers sampled mid-cycle, before the committing edge
    task automatic wr(string req, logic [1:0] sp, logic [5:0] ix, logic [7:0] d,
                      logic exp_en, logic [7:0] exp_mask);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_space = sp; req_index = ix; req_wdata = d;
        #1;
        chk(req, wr_en, exp_en);
        chk(req, wr_mask & {8{exp_en}}, exp_mask);
        @(posedge clk); #1;
        req_valid = 0; req_write = 0;
    endtask

    // read: rd_en mid-cycle, response one edge later
    task automatic rd(string req, logic [1:0] sp, logic [5:0] ix,
                      logic exp_en, logic [7:0] exp_d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_space = sp; req_index = ix;
        #1;
        chk(req, rd_en, exp_en);
        @(posedge clk); #1;
        req_valid = 0;
        chk(req, rsp_valid, 1);
        chk(req, rsp_rdata, exp_d);
    endtask

    task automatic t_reset;
        chk("R1", rsp_valid, 0);
        rd("R1_R6", GFX, 6'h0F, 1, 8'h00);
        rd("R1_R5", CRT, 6'h2B, 0, 8'hFF);
        wr("R1_R2", GFX, 6'h09, 8'hAA, 0, 8'h00);
        rd("R1", CRT, 6'h29, 1, 8'h00);
        rd("R1", SEQ, 6'h01, 1, 8'h00);
    endtask

    task automatic t_group_a;
        wr("R6", GFX, 6'h0F, 8'h05, 1, 8'hFF);
        wr("R2", GFX, 6'h09, 8'hA5, 1, 8'hFF);
        rd("R2", GFX, 6'h09, 1, 8'hA5);
        wr("R6", GFX, 6'h0F, 8'h15, 1, 8'hFF);
        rd("R3", GFX, 6'h09, 0, 8'hFF);
        wr("R6", GFX, 6'h0F, 8'h00, 1, 8'hFF);
        wr("R2", GFX, 6'h09, 8'h3C, 0, 8'h00);
        wr("R6", GFX, 6'h0F, 8'h0D, 1, 8'hFF);
        rd("R2", GFX, 6'h09, 1, 8'hA5);
        wr("R2", GFX, 6'h0A, 8'h11, 1, 8'hFF);
        rd("R2", GFX, 6'h0A, 1, 8'h11);
    endtask

    task automatic t_group_b;
        wr("R6", CRT, 6'h29, 8'h85, 1, 8'hFF);
        wr("R4", CRT, 6'h2B, 8'h5A, 1, 8'hFF);
        rd("R4_R5", CRT, 6'h2B, 1, 8'h5A);
        wr("R6", CRT, 6'h29, 8'h8D, 1, 8'hFF);
        rd("R5", CRT, 6'h2B, 0, 8'hFF);
        wr("R6", CRT, 6'h29, 8'h05, 1, 8'hFF);
        rd("R5", CRT, 6'h2B, 0, 8'hFF);
        wr("R6", CRT, 6'h29, 8'h80, 1, 8'hFF);
        wr("R4", CRT, 6'h2B, 8'h77, 0, 8'h00);
        rd("R6", CRT, 6'h29, 1, 8'h80);
        wr("R6", CRT, 6'h29, 8'h85, 1, 8'hFF);
        rd("R4", CRT, 6'h2B, 1, 8'h5A);
    endtask

    task automatic t_fields;
        wr("R7", CRT, 6'h2A, 8'h01, 1, 8'hFF);
        wr("R7", SEQ, 6'h01, 8'hFF, 1, 8'hFE);
        rd("R7", SEQ, 6'h01, 1, 8'hFE);
        wr("R8", CRT, 6'h2A, 8'h02, 1, 8'hFF);
        wr("R8", SEQ, 6'h01, 8'h00, 1, 8'hC3);
        rd("R8", SEQ, 6'h01, 1, 8'h3C);
        wr("R8", SEQ, 6'h03, 8'hFF, 1, 8'hC0);
        rd("R8", SEQ, 6'h03, 1, 8'hC0);
        wr("R8", GFX, 6'h05, 8'hFF, 1, 8'h9F);
        rd("R8", GFX, 6'h05, 1, 8'h9F);
        wr("R8", CRT, 6'h2A, 8'h00, 1, 8'hFF);
        wr("R7_R8", SEQ, 6'h01, 8'h00, 1, 8'hFF);
        rd("R7_R8", SEQ, 6'h01, 1, 8'h00);
    endtask

    task automatic t_timing;
        wr("R9", GFX, 6'h0D, 8'h20, 1, 8'hFF);
        wr("R9", CRT, 6'h03, 8'h12, 0, 8'h00);
        rd("R9", CRT, 6'h03, 1, 8'h00);
        wr("R9", CRT, 6'h06, 8'h34, 1, 8'hFF);
        rd("R9", CRT, 6'h06, 1, 8'h34);
        wr("R9", GFX, 6'h0D, 8'h01, 1, 8'hFF);
        wr("R9", CRT, 6'h06, 8'h56, 0, 8'h00);
        rd("R9", CRT, 6'h06, 1, 8'h34);
        wr("R9", CRT, 6'h03, 8'h12, 1, 8'hFF);
        rd("R9", CRT, 6'h03, 1, 8'h12);
        wr("R9", CRT, 6'h15, 8'h77, 0, 8'h00);
        wr("R10", GFX, 6'h0D, 8'hC0, 1, 8'hFF);
        wr("R10", MSC, 6'h00, 8'hFF, 1, 8'h3F);
        rd("R10", MSC, 6'h00, 1, 8'h3F);
        wr("R10", GFX, 6'h0D, 8'h40, 1, 8'hFF);
        wr("R10", MSC, 6'h00, 8'hFF, 1, 8'hBF);
        rd("R10", MSC, 6'h00, 1, 8'hBF);
        wr("R10", GFX, 6'h0D, 8'h00, 1, 8'hFF);
    endtask

    task automatic t_compat;
        wr("R11", GFX, 6'h0E, 8'h02, 1, 8'hFF);
        rd("R11", CRT, 6'h03, 0, 8'hFF);
        rd("R11", MSC, 6'h00, 0, 8'hFF);
        rd("R11", GFX, 6'h09, 0, 8'hFF);
        rd("R11", CRT, 6'h17, 0, 8'hFF);
        rd("R11", CRT, 6'h18, 1, 8'h00);
        rd("R11_R6", GFX, 6'h0F, 1, 8'h0D);
        rd("R11", SEQ, 6'h01, 1, 8'h00);
        wr("R11", GFX, 6'h0E, 8'h00, 1, 8'hFF);
        rd("R11", CRT, 6'h03, 1, 8'h12);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        t_reset;
        t_group_a;
        t_group_b;
        t_fields;
        t_timing;
        t_compat;
        done = 1;
        finish_run;
    end

    // watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got 0 exp 1");
            finish_run;
        end
    end
endmodule